// File: doc/BRIEF.md
# Mask-gated frame memory updater

This block copies a stream of camera pixels, already cut to a rectangle, into a frame memory at a programmable X/Y position. A separate one-bit mask memory decides for each location whether the stored picture takes the new camera pixel or keeps its old content. Masked-out locations still consume their input pixel, but no write cycle is issued for them, so only the selected regions of the picture change.

Pixels are 16 bits wide and stored as either RGB 5:6:5 or YUV 4:2:2. In RGB mode each mask bit belongs to one pixel. In YUV mode one bit covers a horizontal pixel pair, so both halves of a chroma pair are always kept or replaced together. Frame and mask addresses come from a base, a line stride and the placement offset. With these, the same engine can fill a single large frame or either of two smaller frames that share the memory.

The mask memory has one cycle of read latency. The block therefore issues each mask address one cycle before the pixel that needs it. After a start pulse there is one prefetch cycle before the first pixel is accepted.

Top module: `mask_frame_updater`

## Requirements
- R1: After reset, pix_ready, fm_we, mask_rd and done are all low.
- R2: A start pulse while idle latches the configuration. The block then accepts cfg_cols x cfg_rows pixels in raster order (columns fastest). Pixel (col,row) is written unchanged to fm_addr = cfg_base + (cfg_y0+row)*cfg_stride + cfg_x0 + col.
- R3: A pixel whose mask bit is 1 gives exactly one write. A pixel whose mask bit is 0 is accepted from the stream with no write, so that location keeps its old value.
- R4: With cfg_rgb=1 (RGB 5:6:5), the mask bit for (col,row) is read at cfg_mask_base + (cfg_y0+row)*cfg_mask_stride + cfg_x0 + col.
- R5: With cfg_rgb=0 (YUV 4:2:2), the mask bit address uses (cfg_x0+col)>>1 as the column term, so two adjacent pixels share one bit.
- R6: mask_rd goes high in the first cycle after start, while pix_ready is still low. pix_ready can first be high in the second cycle after start. mask_bit is taken to be the mask memory contents at the mask_addr of the previous cycle.
- R7: While fm_busy is high, pix_ready is low and no write occurs. Stalls and input gaps neither lose nor repeat pixels.
- R8: done is a one-cycle pulse in the cycle after the last pixel is accepted. pix_ready is low from that cycle until the next start.
- R9: A start pulse, or any change of the configuration inputs, while a rectangle is in progress has no effect on it.
- R10: Rectangles of a single pixel, and rectangles placed at the far corner of the second 176x144 frame (base 25344, stride 176), are addressed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a rectangle (ignored when busy) |
| cfg_rgb | input | 1 | 1 = RGB 5:6:5, 0 = YUV 4:2:2 |
| cfg_base | input | AW | Frame memory base word address |
| cfg_stride | input | CW | Frame line stride in pixels |
| cfg_x0 | input | CW | Placement column |
| cfg_y0 | input | CW | Placement row |
| cfg_cols | input | CW | Rectangle width (>=1) |
| cfg_rows | input | CW | Rectangle height (>=1) |
| cfg_mask_base | input | AW | Mask memory base bit address |
| cfg_mask_stride | input | CW | Mask line stride in bits |
| pix_valid | input | 1 | Input pixel valid |
| pix_ready | output | 1 | Input pixel accepted when high with valid |
| pix_data | input | 16 | Input pixel |
| mask_rd | output | 1 | Mask read enable |
| mask_addr | output | AW | Mask bit address |
| mask_bit | input | 1 | Mask data, one cycle after the address |
| fm_we | output | 1 | Frame memory write strobe |
| fm_addr | output | AW | Frame memory word address |
| fm_wdata | output | 16 | Frame memory write data |
| fm_busy | input | 1 | Frame memory cannot take a write |
| done | output | 1 | Rectangle finished pulse |

## Verification
The hardest case is a pixel that is accepted in the same cycle as the mask address for the next location is switched over. This is worst at a row wrap, or when a stall ends just as the stream resumes. A mask bit that arrives one position late only shows up as a wrong write or a missing write. To reach these cases, the stimulus uses address-derived mask patterns that alternate quickly, and LFSR-driven gaps in valid together with busy pulses. Every accepted pixel is scored against the write that the requirements predict. A start pulse with corrupted configuration is injected in the middle of one rectangle.

// File: rtl/mask_frame_updater.sv
module mask_frame_updater #(
  parameter int AW = 17,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cfg_rgb,
  input  logic [AW-1:0] cfg_base,
  input  logic [CW-1:0] cfg_stride,
  input  logic [CW-1:0] cfg_x0,
  input  logic [CW-1:0] cfg_y0,
  input  logic [CW-1:0] cfg_cols,
  input  logic [CW-1:0] cfg_rows,
  input  logic [AW-1:0] cfg_mask_base,
  input  logic [CW-1:0] cfg_mask_stride,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic [15:0]   pix_data,
  output logic          mask_rd,
  output logic [AW-1:0] mask_addr,
  input  logic          mask_bit,
  output logic          fm_we,
  output logic [AW-1:0] fm_addr,
  output logic [15:0]   fm_wdata,
  input  logic          fm_busy,
  output logic          done
);
  localparam logic [1:0] IDLE = 2'd0, PRE = 2'd1, RUN = 2'd2;

  logic [1:0]    st;
  logic          rgb_q;
  logic [CW-1:0] x0_q, cols_q, rows_q, col, row;
  logic [AW-1:0] stride_q, mstride_q, fm_line, mk_line;

  logic          acc, last_col, last;
  logic [CW-1:0] ncol;
  logic [AW-1:0] nmk_line;

  function automatic logic [AW-1:0] mcol(input logic [CW-1:0] x, input logic [CW-1:0] c, input logic rgb);
    logic [AW-1:0] p;
    p = AW'(x) + AW'(c);
    return rgb ? p : (p >> 1);
  endfunction

  assign pix_ready = (st == RUN) && !fm_busy;
  assign acc       = pix_valid && pix_ready;
  assign last_col  = (col == cols_q - 1'b1);
  assign last      = last_col && (row == rows_q - 1'b1);
  assign ncol      = last_col ? '0 : col + 1'b1;
  assign nmk_line  = last_col ? mk_line + mstride_q : mk_line;

  assign fm_addr   = fm_line + AW'(x0_q) + AW'(col);
  assign fm_wdata  = pix_data;
  assign fm_we     = acc && mask_bit;
  assign mask_rd   = (st != IDLE);
  assign mask_addr = (acc && !last) ? nmk_line + mcol(x0_q, ncol, rgb_q)
                                    : mk_line  + mcol(x0_q, col,  rgb_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      rgb_q     <= 1'b0;
      x0_q      <= '0;
      cols_q    <= '0;
      rows_q    <= '0;
      col       <= '0;
      row       <= '0;
      stride_q  <= '0;
      mstride_q <= '0;
      fm_line   <= '0;
      mk_line   <= '0;
      done      <= 1'b0;
    end else begin
      done <= acc && last;
      case (st)
        IDLE: if (start) begin
          st        <= PRE;
          rgb_q     <= cfg_rgb;
          x0_q      <= cfg_x0;
          cols_q    <= cfg_cols;
          rows_q    <= cfg_rows;
          stride_q  <= AW'(cfg_stride);
          mstride_q <= AW'(cfg_mask_stride);
          fm_line   <= cfg_base + AW'(cfg_y0) * AW'(cfg_stride);
          mk_line   <= cfg_mask_base + AW'(cfg_y0) * AW'(cfg_mask_stride);
          col       <= '0;
          row       <= '0;
        end
        PRE: st <= RUN;
        RUN: if (acc) begin
          if (last) st <= IDLE;
          else begin
            col     <= ncol;
            mk_line <= nmk_line;
            if (last_col) begin
              row     <= row + 1'b1;
              fm_line <= fm_line + stride_q;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module mask_frame_updater_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic          mask_rd,
  input logic          fm_we,
  input logic          fm_busy,
  input logic [AW-1:0] fm_addr,
  input logic          done
);
  // R7
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fm_busy |-> !pix_ready && !fm_we);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pix_ready && !mask_rd);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && !pix_valid) |=> $stable(fm_addr));
  // R6
  mask_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> mask_rd);
endmodule

bind mask_frame_updater mask_frame_updater_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .mask_rd(mask_rd), .fm_we(fm_we), .fm_busy(fm_busy), .fm_addr(fm_addr),
  .done(done));

// File: tb/mask_frame_updater_test.sv
module mask_frame_updater_test;
  localparam int AW = 17, CW = 9;

  logic clk = 0, rst_n = 0, start = 0, cfg_rgb = 0;
  logic [AW-1:0] cfg_base = 0, cfg_mask_base = 0;
  logic [CW-1:0] cfg_stride = 0, cfg_x0 = 0, cfg_y0 = 0, cfg_cols = 0, cfg_rows = 0, cfg_mask_stride = 0;
  logic pix_valid = 0, fm_busy = 0, mask_bit = 0;
  logic [15:0] pix_data = 0;
  logic pix_ready, mask_rd, fm_we, done;
  logic [AW-1:0] mask_addr, fm_addr;
  logic [15:0] fm_wdata;

  int checks = 0, errors = 0, pattern = 0;
  logic [15:0] lfsr = 16'hACE1;
  int exp_addr[$];
  int exp_data[$];

  always #5 clk = ~clk;

  mask_frame_updater #(.AW(AW), .CW(CW)) uut (.*);

  function automatic bit mfun(input int a);
    case (pattern)
      0: return a[0] ^ a[3];
      1: return 1'b1;
      2: return 1'b0;
      default: return a[1] ^ a[2];
    endcase
  endfunction

  always_ff @(posedge clk) if (mask_rd) mask_bit <= mfun(int'(mask_addr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: R2 R3 write scoreboard
  initial forever begin
    @(negedge clk); #2;
    if (fm_we) begin
      if (exp_addr.size() == 0) chk(0, "R3 unexpected write", int'(fm_addr), -1);
      else begin
        int ea, ed;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        chk(int'(fm_addr) == ea, "R2 write address", int'(fm_addr), ea);
        chk(int'(fm_wdata) == ed, "R2 write data", int'(fm_wdata), ed);
      end
    end
  end

  task automatic run_job(input bit rgb, input int base, stride, x0, y0, cols, rows,
                         input int mbase, mstride, input bit stress, input bit inject);
    int idx = 0;
    @(negedge clk);
    cfg_rgb = rgb; cfg_base = AW'(base); cfg_stride = CW'(stride);
    cfg_x0 = CW'(x0); cfg_y0 = CW'(y0); cfg_cols = CW'(cols); cfg_rows = CW'(rows);
    cfg_mask_base = AW'(mbase); cfg_mask_stride = CW'(mstride);
    fm_busy = 0; start = 1;
    @(negedge clk); start = 0; #1;
    chk(mask_rd == 1 && pix_ready == 0, "R6 prefetch cycle", {mask_rd, pix_ready}, 2);
    @(negedge clk);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++) begin
        int ma, fa;
        bit acc = 0;
        fa = base + (y0 + r) * stride + x0 + c;
        ma = mbase + (y0 + r) * mstride + (rgb ? (x0 + c) : ((x0 + c) >> 1));
        while (!acc) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          start = 0;
          if (inject && idx == 5) begin start = 1; cfg_base = '1; cfg_x0 = 0; cfg_cols = 1; end
          fm_busy = stress && lfsr[0] && lfsr[3];
          pix_valid = !(stress && lfsr[5] && lfsr[7]);
          pix_data = 16'(fa * 7 + idx);
          #1;
          if (fm_busy && pix_valid) chk(!pix_ready, "R7 ready low on busy", pix_ready, 0);
          if (idx == 0 && !fm_busy && r == 0 && c == 0 && pix_valid)
            chk(pix_ready, "R6 ready second cycle", pix_ready, 1);
          if (pix_valid && pix_ready) begin
            acc = 1;
            if (mfun(ma)) begin exp_addr.push_back(fa); exp_data.push_back(int'(pix_data)); end
          end
          idx++;
          @(negedge clk);
        end
      end
    pix_valid = 0; fm_busy = 0; start = 0; #1;
    chk(done == 1, "R8 done after last pixel", done, 1);
    chk(pix_ready == 0, "R8 ready low with done", pix_ready, 0);
    @(negedge clk); #1;
    chk(done == 0, "R8 done single cycle", done, 0);
    chk(exp_addr.size() == 0, "R3 missing writes", exp_addr.size(), 0);
    chk(pix_ready == 0, "R8 idle until next start", pix_ready, 0);
  endtask

  initial begin
    #(200000 * 10);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    #1;
    chk(pix_ready == 0 && fm_we == 0 && mask_rd == 0 && done == 0, "R1 reset outputs",
        {pix_ready, fm_we, mask_rd, done}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(pix_ready == 0 && mask_rd == 0 && done == 0, "R1 idle after reset", {pix_ready, mask_rd, done}, 0);
    // R4 RGB, checkerboard-like mask
    pattern = 0; run_job(1, 0, 320, 5, 3, 6, 4, 1000, 320, 0, 0);
    // R5 YUV pairs with stalls, R9 mid-stream start
    pattern = 3; run_job(0, 100, 320, 4, 2, 8, 3, 50, 160, 1, 1);
    // R5 odd x0 pairing
    pattern = 0; run_job(0, 0, 320, 3, 7, 7, 2, 9, 160, 1, 0);
    // R10 second frame corner, all writes
    pattern = 1; run_job(1, 25344, 176, 170, 140, 6, 4, 0, 176, 1, 0);
    // R10 single pixel
    pattern = 1; run_job(0, 25344, 176, 175, 143, 1, 1, 0, 88, 0, 0);
    // R3 all masked off: no writes at all
    pattern = 2; run_job(1, 0, 320, 0, 0, 5, 3, 0, 320, 1, 0);
    // R2 full row width with stress
    pattern = 3; run_job(1, 0, 320, 0, 239, 320, 1, 0, 320, 1, 0);
    summary();
  end
endmodule